// File: doc/BRIEF.md
# Snoop Response Ack Collector

A directory that serves a DMA transaction sends a snoop to every last-level cache. It may not finish the transaction until each of those caches has answered. This block is the part of the directory that waits for those answers. A start pulse arms it and loads a pending count equal to the number of last-level caches. It also clears two flags: one records that some cache still holds a shared copy, the other records that some cache supplied the line's data. Each snoop response arrives on a valid/ready stream and is classified by a two-bit kind. The block lowers the count by one and updates the flags. The latest data carried by a response is kept.

When the count reaches zero, the block raises a one-cycle completion trigger. A side bit tells the state machine which completion it is: either completion with a sharer still present, or completion with no sharers left. A transaction may also be started with a memory read still outstanding. In that case responses still update the count and the flags, but completion waits for the memory-done pulse. Illegal traffic raises one-cycle error pulses. Illegal traffic is a response whose ack field is zero, or a response that arrives when nothing is pending.

The response stream never back-pressures. `rsp_ready` is low only during reset, so a response is taken in every cycle in which `rsp_valid` is high and reset is released. Control and status pins are plain levels or pulses.

Top module: `snoop_ack_collector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, these outputs are 0: `busy`, `trig_valid`, `trig_sharers`, `sharer_seen`, `cache_dirty`, `captured_data`, `err_zero_ack` and `err_stray`.
- R2: A `start` pulse loads the pending count with NUM_CACHES and clears `sharer_seen`, `cache_dirty` and `captured_data` to zero. `busy` is 1 from the next cycle on. A `start` while `busy` is 1 abandons the old transaction without a trigger.
- R3: Each accepted response with a nonzero ack field lowers the pending count by exactly one, whatever the ack field's value (data responses carry 2). The trigger therefore follows the NUM_CACHES-th such response.
- R4: The kinds are encoded 0 = plain ack, 1 = shared ack, 2 = shared data, 3 = exclusive data. Kinds 1 and 2 set `sharer_seen`; kinds 0 and 3 leave it unchanged.
- R5: Kinds 2 and 3 set `cache_dirty` and load `rsp_data` into `captured_data`. The latest data response wins. Kinds 0 and 1 leave both unchanged.
- R6: With no memory wait pending, `trig_valid` is high for exactly one cycle, in the cycle after the response that brings the count to zero. `trig_sharers` is 1 for the "all acks, sharers present" trigger and 0 for the "all acks, no sharers" trigger.
- R7: When `start_mem_wait` is 1 at `start`, no trigger is issued until `mem_done` is seen. If the count is already zero, the trigger comes in the cycle after `mem_done`. A `mem_done` that arrives before the count reaches zero only clears the wait.
- R8: A response accepted while the count is open with an ack field of 0 pulses `err_zero_ack` in the next cycle. It has no effect on the count, the flags or the data.
- R9: A response accepted in any of these cases pulses `err_stray` in the next cycle and is otherwise ignored: while `busy` is 0, while the count is already zero, or in the same cycle as `start`.
- R10: The trigger ends the transaction. `busy` is 0 while `trig_valid` is high. A later `mem_done` or response cannot produce a second trigger.
- R11: `rsp_ready` is 0 during reset and 1 in every cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm a new transaction (pulse) |
| start_mem_wait | input | 1 | With `start`: memory data is still outstanding |
| mem_done | input | 1 | Memory data has arrived (pulse) |
| rsp_valid | input | 1 | Snoop response valid |
| rsp_ready | output | 1 | Snoop response ready (never back-pressures) |
| rsp_kind | input | 2 | 0 ack, 1 shared ack, 2 shared data, 3 exclusive data |
| rsp_acks | input | ACK_W | Ack field of the response; zero is illegal |
| rsp_data | input | DATA_W | Line data carried by data responses |
| busy | output | 1 | A transaction is armed |
| trig_valid | output | 1 | One-cycle completion trigger |
| trig_sharers | output | 1 | Trigger flavour: 1 sharers present, 0 no sharers |
| sharer_seen | output | 1 | A responder reported a shared copy |
| cache_dirty | output | 1 | A responder supplied data |
| captured_data | output | DATA_W | Latest data supplied by a responder |
| err_zero_ack | output | 1 | Zero ack field seen (pulse) |
| err_stray | output | 1 | Response with nothing pending (pulse) |

## Verification
An off-by-one in the pending count shows up at the ports on the response that should have completed the transaction. Depending on the direction of the error, `trig_valid` appears one response early or does not appear at all, and `busy` stays high in the second case. A stuck or wrongly set flag shows up as a wrong `trig_sharers` value in the trigger cycle. A sweep over every ordering of response kinds for a small cache count therefore exposes it within one transaction. A memory-wait flag that is lost or cleared early shows up as a trigger before `mem_done`, or as no trigger after it. A leaking error path shows up as a changed count or flag on the next legal completion.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [1:0] {
    RK_ACK         = 2'd0,
    RK_ACK_SHARED  = 2'd1,
    RK_DATA_SHARED = 2'd2,
    RK_DATA_EXCL   = 2'd3
  } rsp_kind_t;

  function automatic logic kind_marks_sharer(rsp_kind_t k);
    return (k == RK_ACK_SHARED) || (k == RK_DATA_SHARED);
  endfunction

  function automatic logic kind_has_data(rsp_kind_t k);
    return (k == RK_DATA_SHARED) || (k == RK_DATA_EXCL);
  endfunction

endpackage

// File: rtl/sac_rsp_decode.sv
module sac_rsp_decode
  import sac_pkg::*;
#(
  parameter int ACK_W = 2
) (
  input  logic             accept,
  input  logic             window_open,
  input  logic [1:0]       kind,
  input  logic [ACK_W-1:0] acks,
  output logic             take,
  output logic             mark_sharer,
  output logic             mark_data,
  output logic             bad_ack,
  output logic             stray
);

  rsp_kind_t kind_e;
  logic      acks_zero;

  always_comb begin
    kind_e      = rsp_kind_t'(kind);
    acks_zero   = (acks == '0);
    stray       = accept & ~window_open;
    bad_ack     = accept & window_open & acks_zero;
    take        = accept & window_open & ~acks_zero;
    mark_sharer = take & kind_marks_sharer(kind_e);
    mark_data   = take & kind_has_data(kind_e);
  end

endmodule

// File: rtl/sac_pend_count.sv
module sac_pend_count #(
  parameter int NUM_CACHES = 4,
  parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             is_zero
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(NUM_CACHES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  always_comb begin
    if (load)      cnt_nxt = LOAD_VAL;
    else if (dec)  cnt_nxt = cnt_q - ONE;
    else           cnt_nxt = cnt_q;
    is_zero = (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/sac_resp_flags.sv
module sac_resp_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mark_sharer,
  input  logic              mark_data,
  input  logic [DATA_W-1:0] data_in,
  output logic              sharer_q,
  output logic              sharer_nxt,
  output logic              dirty_q,
  output logic [DATA_W-1:0] data_q
);

  always_comb begin
    sharer_nxt = clear ? 1'b0 : (sharer_q | mark_sharer);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sharer_q <= 1'b0;
      dirty_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      sharer_q <= sharer_nxt;
      if (clear) begin
        dirty_q <= 1'b0;
        data_q  <= '0;
      end else if (mark_data) begin
        dirty_q <= 1'b1;
        data_q  <= data_in;
      end
    end
  end

endmodule

// File: rtl/snoop_ack_collector.sv
module snoop_ack_collector #(
  parameter int NUM_CACHES = 4,
  parameter int DATA_W     = 32,
  parameter int ACK_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_mem_wait,
  input  logic              mem_done,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_kind,
  input  logic [ACK_W-1:0]  rsp_acks,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              trig_valid,
  output logic              trig_sharers,
  output logic              sharer_seen,
  output logic              cache_dirty,
  output logic [DATA_W-1:0] captured_data,
  output logic              err_zero_ack,
  output logic              err_stray
);

  localparam int CNT_W = $clog2(NUM_CACHES + 1);

  logic             busy_q, wait_q, trig_q, trig_sh_q;
  logic             err_zero_q, err_stray_q, ready_q;
  logic             mem_wait;
  logic [CNT_W-1:0] pend_cnt, cnt_nxt;
  logic             cnt_zero;
  logic             accept, window_open;
  logic             take, mark_sharer, mark_data, bad_ack, stray;
  logic             sharer_nxt;
  logic             wait_nxt, complete;

  assign accept      = rsp_valid & ready_q;
  assign window_open = busy_q & ~start & ~cnt_zero;
  assign mem_wait    = wait_q;

  sac_rsp_decode #(.ACK_W(ACK_W)) u_decode (
    .accept      (accept),
    .window_open (window_open),
    .kind        (rsp_kind),
    .acks        (rsp_acks),
    .take        (take),
    .mark_sharer (mark_sharer),
    .mark_data   (mark_data),
    .bad_ack     (bad_ack),
    .stray       (stray)
  );

  sac_pend_count #(.NUM_CACHES(NUM_CACHES), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .dec     (take),
    .cnt_q   (pend_cnt),
    .cnt_nxt (cnt_nxt),
    .is_zero (cnt_zero)
  );

  sac_resp_flags #(.DATA_W(DATA_W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start),
    .mark_sharer (mark_sharer),
    .mark_data   (mark_data),
    .data_in     (rsp_data),
    .sharer_q    (sharer_seen),
    .sharer_nxt  (sharer_nxt),
    .dirty_q     (cache_dirty),
    .data_q      (captured_data)
  );

  always_comb begin
    wait_nxt = start ? start_mem_wait : (wait_q & ~mem_done);
    complete = busy_q & ~start & (cnt_nxt == '0) & ~wait_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      wait_q      <= 1'b0;
      trig_q      <= 1'b0;
      trig_sh_q   <= 1'b0;
      err_zero_q  <= 1'b0;
      err_stray_q <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      wait_q      <= wait_nxt;
      err_zero_q  <= bad_ack;
      err_stray_q <= stray;
      trig_q      <= complete;
      if (complete) trig_sh_q <= sharer_nxt;
      if (start)         busy_q <= 1'b1;
      else if (complete) busy_q <= 1'b0;
    end
  end

  assign rsp_ready    = ready_q;
  assign busy         = busy_q;
  assign trig_valid   = trig_q;
  assign trig_sharers = trig_sh_q;
  assign err_zero_ack = err_zero_q;
  assign err_stray    = err_stray_q;

endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int NUM_CACHES = 4,
  parameter int ACK_W      = 2
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 start,
  input logic                                 mem_done,
  input logic                                 rsp_valid,
  input logic                                 rsp_ready,
  input logic [ACK_W-1:0]                     rsp_acks,
  input logic                                 busy,
  input logic                                 trig_valid,
  input logic                                 sharer_seen,
  input logic                                 cache_dirty,
  input logic                                 err_zero_ack,
  input logic                                 err_stray,
  input logic [$clog2(NUM_CACHES + 1)-1:0]    pend_cnt,
  input logic                                 mem_wait
);

  localparam int CNT_W = $clog2(NUM_CACHES + 1);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && pend_cnt == CNT_W'(NUM_CACHES) && !sharer_seen && !cache_dirty); // R2

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && rsp_valid && rsp_ready && rsp_acks != '0 && pend_cnt != '0
    |=> pend_cnt == CNT_W'($past(pend_cnt) - 1'b1)); // R3

  AST_SHARER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sharer_seen && !start |=> sharer_seen); // R4

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid); // R6

  AST_TRIG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> pend_cnt == '0); // R6

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_wait && !mem_done && !start |=> !trig_valid); // R7

  AST_ZERO_ACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && rsp_valid && rsp_ready && rsp_acks == '0 && pend_cnt != '0
    |=> err_zero_ack && $stable(pend_cnt)); // R8

  AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !busy |=> err_stray); // R9

  AST_TRIG_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> !busy); // R10

endmodule

bind snoop_ack_collector sac_checker #(
  .NUM_CACHES (NUM_CACHES),
  .ACK_W      (ACK_W)
) u_chk (.*);

// File: tb/snoop_ack_collector_tb.sv
module snoop_ack_collector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int DW = 16;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, start_mem_wait = 1'b0, mem_done = 1'b0;
  logic          rsp_valid = 1'b0;
  logic          rsp_ready;
  logic [1:0]    rsp_kind = 2'd0;
  logic [AW-1:0] rsp_acks = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          busy, trig_valid, trig_sharers, sharer_seen, cache_dirty;
  logic [DW-1:0] captured_data;
  logic          err_zero_ack, err_stray;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  snoop_ack_collector #(.NUM_CACHES(NC), .DATA_W(DW), .ACK_W(AW)) u_dut (
    .clk, .rst_n, .start, .start_mem_wait, .mem_done,
    .rsp_valid, .rsp_ready, .rsp_kind, .rsp_acks, .rsp_data,
    .busy, .trig_valid, .trig_sharers, .sharer_seen, .cache_dirty,
    .captured_data, .err_zero_ack, .err_stray
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_start(input logic w);
    start = 1'b1; start_mem_wait = w;
    @(negedge clk);
    start = 1'b0; start_mem_wait = 1'b0;
  endtask

  task automatic send(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rsp_valid = 1'b1; rsp_kind = k; rsp_acks = a; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_acks = '0;
  endtask

  task automatic pulse_mem();
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
  endtask

  function automatic logic [AW-1:0] acks_for(input logic [1:0] k);
    return (k >= 2'd2) ? AW'(2) : AW'(1);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL R6 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R11", "ready in reset", 32'(rsp_ready), 0);
    chk("R1", "busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    idle();
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "trig", 32'(trig_valid), 0);
    chk("R1", "trig_sharers", 32'(trig_sharers), 0);
    chk("R1", "errors", 32'({err_zero_ack, err_stray}), 0);
    chk("R1", "flags", 32'({sharer_seen, cache_dirty}), 0);
    chk("R1", "data", 32'(captured_data), 0);
    chk("R11", "ready after reset", 32'(rsp_ready), 1);

    // R9: response while idle is stray and ignored
    send(2'd2, 2'd2, 16'hBEEF);
    chk("R9", "stray idle err", 32'(err_stray), 1);
    chk("R9", "stray idle flags", 32'({sharer_seen, cache_dirty}), 0);
    chk("R9", "stray idle trig", 32'(trig_valid), 0);
    idle();
    chk("R9", "stray pulse ends", 32'(err_stray), 0);

    // exhaustive sweep of kind orderings and memory-wait modes
    for (int mode = 0; mode < 3; mode++) begin
      for (int seq = 0; seq < 64; seq++) begin
        logic          exp_sh, exp_dy;
        logic [DW-1:0] exp_d;
        exp_sh = 1'b0; exp_dy = 1'b0; exp_d = '0;
        do_start(mode != 0);
        chk("R2", "busy after start", 32'(busy), 1);
        chk("R2", "cleared flags", 32'({sharer_seen, cache_dirty}), 0);
        chk("R2", "cleared data", 32'(captured_data), 0);
        if (mode == 1) begin
          pulse_mem();
          chk("R7", "early mem_done no trig", 32'(trig_valid), 0);
        end
        for (int i = 0; i < NC; i++) begin
          logic [1:0]    k;
          logic [DW-1:0] dv;
          k  = 2'((seq >> (2 * i)) & 3);
          dv = DW'((seq << 10) | (mode << 8) | (i + 1));
          if (k == 2'd1 || k == 2'd2) exp_sh = 1'b1;
          if (k >= 2'd2) begin exp_dy = 1'b1; exp_d = dv; end
          send(k, acks_for(k), dv);
          chk("R4", "sharer_seen", 32'(sharer_seen), 32'(exp_sh));
          chk("R5", "cache_dirty", 32'(cache_dirty), 32'(exp_dy));
          chk("R5", "captured_data", 32'(captured_data), 32'(exp_d));
          if (i < NC - 1 || mode == 2) begin
            chk("R3", "no early trig", 32'(trig_valid), 0);
          end else begin
            chk("R3", "trig on last response", 32'(trig_valid), 1);
            chk("R6", "trig flavour", 32'(trig_sharers), 32'(exp_sh));
            chk("R10", "idle at trig", 32'(busy), 0);
          end
        end
        if (mode == 2) begin
          chk("R7", "busy while waiting", 32'(busy), 1);
          pulse_mem();
          chk("R7", "trig after mem_done", 32'(trig_valid), 1);
          chk("R7", "trig flavour", 32'(trig_sharers), 32'(exp_sh));
        end
        idle();
        chk("R6", "single-cycle trig", 32'(trig_valid), 0);
        pulse_mem();
        chk("R10", "no second trig", 32'(trig_valid), 0);
      end
    end

    // R8: zero ack field flagged and ignored
    do_start(1'b0);
    send(2'd2, 2'd0, 16'h1234);
    chk("R8", "zero ack err", 32'(err_zero_ack), 1);
    chk("R8", "zero ack flags", 32'({sharer_seen, cache_dirty}), 0);
    chk("R8", "zero ack data", 32'(captured_data), 0);
    send(2'd0, 2'd1, 16'h0);
    chk("R8", "zero ack pulse ends", 32'(err_zero_ack), 0);
    send(2'd0, 2'd1, 16'h0);
    chk("R8", "count untouched", 32'(trig_valid), 0);
    send(2'd0, 2'd1, 16'h0);
    chk("R8", "trig after three legal", 32'(trig_valid), 1);
    chk("R8", "no sharers", 32'(trig_sharers), 0);
    idle();

    // R9: response after count reached zero during memory wait
    do_start(1'b1);
    for (int i = 0; i < NC; i++) send(2'd0, 2'd1, 16'h0);
    send(2'd2, 2'd2, 16'h5555);
    chk("R9", "stray at zero err", 32'(err_stray), 1);
    chk("R9", "stray at zero flags", 32'({sharer_seen, cache_dirty}), 0);
    pulse_mem();
    chk("R7", "trig after wait", 32'(trig_valid), 1);
    chk("R9", "flavour unchanged", 32'(trig_sharers), 0);
    idle();

    // R2: restart abandons state
    do_start(1'b0);
    send(2'd1, 2'd1, 16'h0);
    chk("R4", "shared ack sets", 32'(sharer_seen), 1);
    do_start(1'b0);
    chk("R2", "restart clears sharer", 32'(sharer_seen), 0);
    chk("R2", "restart no trig", 32'(trig_valid), 0);
    send(2'd0, 2'd1, 16'h0);
    send(2'd0, 2'd1, 16'h0);
    chk("R2", "restart reloads count", 32'(trig_valid), 0);
    send(2'd3, 2'd2, 16'h7777);
    chk("R2", "trig after reload", 32'(trig_valid), 1);
    chk("R6", "exclusive no sharers", 32'(trig_sharers), 0);
    chk("R5", "exclusive data", 32'(captured_data), 32'h7777);
    idle();

    // R9: response in the same cycle as start
    start = 1'b1; rsp_valid = 1'b1; rsp_kind = 2'd1; rsp_acks = 2'd1;
    @(negedge clk);
    start = 1'b0; rsp_valid = 1'b0;
    chk("R9", "start-cycle stray", 32'(err_stray), 1);
    chk("R9", "start-cycle ignored", 32'(sharer_seen), 0);
    for (int i = 0; i < NC; i++) send(2'd0, 2'd1, 16'h0);
    chk("R3", "full count after start-cycle stray", 32'(trig_valid), 1);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule